// File: doc/BRIEF.md
# Windowed Outbound Address Translator

This block turns processor addresses that land in an outbound memory region into 64-bit bus addresses. The region is cut into a table of equal windows, and one shared size index sets how wide every window is. Each window entry carries a 64-bit target offset and its own enable flag. An address is translated only when the global translation enable is set, the address falls inside a populated window, and that window is enabled. In that case the upper bits come from the window's offset and the bits below the window size pass through unchanged.

Configuration uses a plain word-wide register bus: a write strobe with address and data, and a combinational read port. The lookup path is registered. An address presented with its valid flag gives a result one clock later, made of a valid flag, a hit flag and the translated address.

Top module: `outbound_xlat`

## Requirements
- R1: While reset is held, out_valid, out_hit and out_addr are 0, and every configuration register reads back 0.
- R2: The control register at byte offset 0x004 holds the translation enable in bit 1. Only that bit is stored and read back. While it is 0, every lookup misses.
- R3: The size register at byte offset 0x030 keeps the low 3 bits of the written word and reads back only those bits. Each window then spans 2^(UNIT_SHIFT + index) bytes, where UNIT_SHIFT = 20 gives megabytes.
- R4: Window n has its low word at byte offset 0x200 + 8n and its high word at 0x204 + 8n. Both words read back exactly as written.
- R5: The window number of an address is (address − REGION_BASE) shifted right by the window-size bit count. An address below REGION_BASE, or one whose window number is NUM_WIN or more, misses.
- R6: On a hit, out_addr equals {high word, low word} of the selected window, with its low window-size bits replaced by the same bits of the input address. Bit 0 of the low word is therefore never passed through.
- R7: A lookup whose window has bit 0 of its low word clear misses. Every miss drives out_addr to 0.
- R8: out_valid is in_valid delayed by one clock. A cycle without in_valid gives out_hit = 0 and out_addr = 0.
- R9: A write is ignored, and a read returns 0, when the offset is not word aligned, matches no register, or names a window number of NUM_WIN or more.
- R10: A lookup in the same cycle as a configuration write uses the configuration that held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| in_valid | input | 1 | Lookup request valid |
| in_addr | input | ADDR_W | Processor address to translate |
| out_valid | output | 1 | Lookup result valid, one clock after in_valid |
| out_hit | output | 1 | Translation succeeded |
| out_addr | output | 64 | Translated bus address, 0 on a miss |

## Verification
The bench builds the block with NUM_WIN = 8, UNIT_SHIFT = 4 and REGION_BASE = 0x4000_0000. With these values windows are 16 bytes to 2 KiB wide, so each window, the first address past the table, and addresses just below the region can all be reached with short address offsets under every size index. Because the table has only 8 windows, the table offsets for windows 8 to 31 are unmapped, which tests decoding of windows past the table. A behavioural model predicts the result of every lookup. It also covers writes that coincide with a lookup and random sweeps across all eight size settings.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int CFG_AW = 12;

    // register byte offsets; the table stride of 8 is decoded by address bits
    localparam logic [CFG_AW-1:0] CTRL_OFF = 12'h004;
    localparam logic [CFG_AW-1:0] SIZE_OFF = 12'h030;
    localparam logic [CFG_AW-1:0] TBL_OFF  = 12'h200;

    // control bit carrying the translation enable
    localparam int EN_BIT = 1;

    typedef struct packed {
        logic        valid;
        logic        hit;
        logic [63:0] addr;
    } xl_res_t;

endpackage

// File: rtl/xlat_cfg_regs.sv
module xlat_cfg_regs
    import xlat_pkg::*;
#(
    parameter int NUM_WIN = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_wr,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [31:0]                  cfg_wdata,
    output logic [31:0]                  cfg_rdata,
    output logic                         xl_en,
    output logic [2:0]                   size_idx,
    output logic [NUM_WIN-1:0][31:0]     win_lo,
    output logic [NUM_WIN-1:0][31:0]     win_hi
);

    localparam int IDX_W = $clog2(NUM_WIN);
    localparam logic [CFG_AW-1:0] TBL_END = CFG_AW'(TBL_OFF + 8 * NUM_WIN);

    typedef struct packed {
        logic                     en;
        logic [2:0]               size;
        logic [NUM_WIN-1:0][31:0] lo;
        logic [NUM_WIN-1:0][31:0] hi;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic             aligned;
    logic             in_tbl;
    logic [IDX_W-1:0] widx;

    always_comb begin
        aligned = (cfg_addr[1:0] == 2'b00);
        in_tbl  = (cfg_addr >= TBL_OFF) && (cfg_addr < TBL_END);
        widx    = cfg_addr[IDX_W+2:3];
    end

    // next state
    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr && aligned) begin
            if (cfg_addr == CTRL_OFF) begin
                cfg_d.en = cfg_wdata[EN_BIT];
            end else if (cfg_addr == SIZE_OFF) begin
                cfg_d.size = cfg_wdata[2:0];
            end else if (in_tbl) begin
                if (cfg_addr[2]) begin
                    cfg_d.hi[widx] = cfg_wdata;
                end else begin
                    cfg_d.lo[widx] = cfg_wdata;
                end
            end
        end
    end

    // read port
    always_comb begin
        cfg_rdata = '0;
        if (aligned) begin
            if (cfg_addr == CTRL_OFF) begin
                cfg_rdata[EN_BIT] = cfg_q.en;
            end else if (cfg_addr == SIZE_OFF) begin
                cfg_rdata[2:0] = cfg_q.size;
            end else if (in_tbl) begin
                cfg_rdata = cfg_addr[2] ? cfg_q.hi[widx] : cfg_q.lo[widx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign xl_en    = cfg_q.en;
    assign size_idx = cfg_q.size;
    assign win_lo   = cfg_q.lo;
    assign win_hi   = cfg_q.hi;

endmodule

// File: rtl/xlat_win_sel.sv
module xlat_win_sel #(
    parameter int                NUM_WIN     = 32,
    parameter int                ADDR_W      = 32,
    parameter int                UNIT_SHIFT  = 20,
    parameter logic [ADDR_W-1:0] REGION_BASE = '0
) (
    input  logic [ADDR_W-1:0]        in_addr,
    input  logic                     xl_en,
    input  logic [2:0]               size_idx,
    input  logic [NUM_WIN-1:0][31:0] win_lo,
    input  logic [NUM_WIN-1:0][31:0] win_hi,
    output logic                     hit,
    output logic [63:0]              xaddr
);

    logic [6:0]               sh;
    logic [ADDR_W-1:0]        rel;
    logic [ADDR_W-1:0]        wnum;
    logic                     in_range;
    logic [NUM_WIN-1:0][63:0] cand;
    logic [63:0]              entry;
    logic [63:0]              mask;

    always_comb begin
        sh       = 7'(UNIT_SHIFT) + 7'(size_idx);
        rel      = in_addr - REGION_BASE;
        wnum     = rel >> sh;
        in_range = (in_addr >= REGION_BASE) && (wnum < ADDR_W'(NUM_WIN));
    end

    // one comparator per window; at most one candidate is non-zero
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        assign cand[i] = (in_range && (wnum == ADDR_W'(i))) ?
                         {win_hi[i], win_lo[i]} : 64'd0;
    end

    always_comb begin
        entry = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            entry = entry | cand[i];
        end
        mask  = (64'd1 << sh) - 64'd1;
        xaddr = (entry & ~mask) | (64'(in_addr) & mask);
        hit   = xl_en & entry[0];
    end

endmodule

// File: rtl/outbound_xlat.sv
module outbound_xlat
    import xlat_pkg::*;
#(
    parameter int                NUM_WIN     = 32,
    parameter int                ADDR_W      = 32,
    parameter int                UNIT_SHIFT  = 20,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h5000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [11:0]       cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic [63:0]       out_addr
);

    logic                     xl_en;
    logic [2:0]               size_idx;
    logic [NUM_WIN-1:0][31:0] win_lo;
    logic [NUM_WIN-1:0][31:0] win_hi;
    logic                     sel_hit;
    logic [63:0]              sel_addr;

    xl_res_t res_d, res_q;

    xlat_cfg_regs #(
        .NUM_WIN (NUM_WIN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .xl_en     (xl_en),
        .size_idx  (size_idx),
        .win_lo    (win_lo),
        .win_hi    (win_hi)
    );

    xlat_win_sel #(
        .NUM_WIN     (NUM_WIN),
        .ADDR_W      (ADDR_W),
        .UNIT_SHIFT  (UNIT_SHIFT),
        .REGION_BASE (REGION_BASE)
    ) u_sel (
        .in_addr  (in_addr),
        .xl_en    (xl_en),
        .size_idx (size_idx),
        .win_lo   (win_lo),
        .win_hi   (win_hi),
        .hit      (sel_hit),
        .xaddr    (sel_addr)
    );

    always_comb begin
        res_d.valid = in_valid;
        res_d.hit   = in_valid & sel_hit;
        res_d.addr  = (in_valid && sel_hit) ? sel_addr : 64'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_hit   = res_q.hit;
    assign out_addr  = res_q.addr;

endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
    parameter int                ADDR_W      = 32,
    parameter int                UNIT_SHIFT  = 20,
    parameter logic [ADDR_W-1:0] REGION_BASE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              xl_en,
    input logic [2:0]        size_idx,
    input logic              out_valid,
    input logic              out_hit,
    input logic [63:0]       out_addr
);

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_hit && out_addr == 64'd0));

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_hit |-> out_addr == 64'd0);

    assert_off_misses_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_en |=> !out_hit);

    assert_below_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr < REGION_BASE) |=> !out_hit);

    assert_size_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(size_idx));

    assert_low_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_hit ||
                      out_addr[UNIT_SHIFT-1:0] == $past(in_addr[UNIT_SHIFT-1:0])));

endmodule

bind outbound_xlat xlat_checker #(
    .ADDR_W      (ADDR_W),
    .UNIT_SHIFT  (UNIT_SHIFT),
    .REGION_BASE (REGION_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .xl_en     (xl_en),
    .size_idx  (size_idx),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_addr  (out_addr)
);

// File: tb/tb_outbound_xlat.sv
module tb_outbound_xlat;

    localparam int          NW   = 8;
    localparam int          US   = 4;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid, out_hit;
    logic [63:0] out_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    outbound_xlat #(
        .NUM_WIN (NW), .ADDR_W (32), .UNIT_SHIFT (US), .REGION_BASE (BASE)
    ) dut (
        .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_addr (cfg_addr),
        .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata), .in_valid (in_valid),
        .in_addr (in_addr), .out_valid (out_valid), .out_hit (out_hit),
        .out_addr (out_addr)
    );

    // ---------------- behavioural model ----------------
    logic        m_en;
    logic [2:0]  m_size;
    logic [31:0] m_lo [NW];
    logic [31:0] m_hi [NW];
    logic        exp_v = 1'b0, exp_h = 1'b0;
    logic [63:0] exp_a = '0;

    function automatic logic [64:0] model_lookup(input logic [31:0] a);
        int          sh;
        logic [31:0] idx;
        logic [63:0] ent, mask;
        sh = US + int'(m_size);
        if (!m_en || a < BASE) return 65'd0;
        idx = (a - BASE) >> sh;
        if (idx >= NW) return 65'd0;
        if (!m_lo[idx][0]) return 65'd0;
        ent  = {m_hi[idx], m_lo[idx]};
        mask = (64'd1 << sh) - 64'd1;
        return {1'b1, (ent & ~mask) | ({32'd0, a} & mask)};
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        int n;
        if (a[1:0] != 2'b00) return;
        if (a == 12'h004) m_en = d[1];
        else if (a == 12'h030) m_size = d[2:0];
        else if (a >= 12'h200 && a < 12'h200 + 8 * NW) begin
            n = int'(a - 12'h200) / 8;
            if (a[2]) m_hi[n] = d; else m_lo[n] = d;
        end
    endtask

    always @(posedge clk) begin
        logic [64:0] r;
        if (!rst_n) begin
            m_en = 1'b0; m_size = 3'd0;
            for (int i = 0; i < NW; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
            exp_v <= 1'b0; exp_h <= 1'b0; exp_a <= '0;
        end else begin
            r = in_valid ? model_lookup(in_addr) : 65'd0;  // old config (R10)
            exp_v <= in_valid;
            exp_h <= r[64];
            exp_a <= r[63:0];
            if (cfg_wr) model_write(cfg_addr, cfg_wdata);
        end
    end

    // per-clock comparison of the lookup outputs (R5 R6 R7 R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (out_valid !== exp_v || out_hit !== exp_h || out_addr !== exp_a) begin
                errors++;
                $display("FAIL R8/R6/R7 lookup: got v=%0b h=%0b a=%h exp v=%0b h=%0b a=%h",
                         out_valid, out_hit, out_addr, exp_v, exp_h, exp_a);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag,
                         input logic [63:0] got, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h exp %h", tag, got, expv);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] expv, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(cfg_rdata === expv, tag, 64'(cfg_rdata), 64'(expv));
    endtask

    task automatic look(input logic [31:0] a);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] lo_val(input int i);
        return 32'hA000_0000 + 32'(i) * 32'h100 + ((i == 3) ? 32'd0 : 32'd1);
    endfunction

    // ---------------- stimulus ----------------
    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0 && out_hit === 1'b0 && out_addr === 64'd0,
              "R1 outputs in reset", out_addr, 64'd0);
        cfg_addr = 12'h004; #1;
        check(cfg_rdata === 32'd0, "R1 ctrl in reset", 64'(cfg_rdata), 64'd0);
        cfg_addr = 12'h204; #1;
        check(cfg_rdata === 32'd0, "R1 hi0 in reset", 64'(cfg_rdata), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7/R2: nothing enabled -> miss
        look(BASE + 32'h15);

        // R4: program table
        for (int i = 0; i < NW; i++) begin
            wr(12'h200 + 12'(8 * i), lo_val(i));
            wr(12'h204 + 12'(8 * i), 32'h10 + 32'(i));
        end
        rd(12'h218, lo_val(3), "R4 lo3 readback");
        rd(12'h23C, 32'h17, "R4 hi7 readback");

        // R2: enable bit only
        look(BASE + 32'h25);                 // entries set, still disabled
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h004, 32'h2, "R2 ctrl readback");

        // R5 R6 R7 with 16-byte windows
        for (int i = 0; i < NW + 1; i++) look(BASE + 32'(16 * i) + 32'h5);
        look(BASE - 32'd1);
        look(BASE + 32'h7F);

        // R3: size keeps low 3 bits
        wr(12'h030, 32'hFFFF_FFFA);
        rd(12'h030, 32'h2, "R3 size readback");
        for (int i = 0; i < NW + 1; i++) look(BASE + 32'(64 * i) + 32'h2A);
        wr(12'h030, 32'h7);
        look(BASE + 32'(2048 * 5) + 32'h3FF);
        look(BASE + 32'(2048 * 8));

        // R9: ignored writes
        wr(12'h240, 32'h1);
        rd(12'h240, 32'h0, "R9 window past table");
        wr(12'h202, 32'hFFFF_FFFF);
        rd(12'h200, lo_val(0), "R9 misaligned write ignored");
        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h100, 32'h0, "R9 unmapped offset");
        rd(12'h004, 32'h2, "R9 ctrl untouched");
        look(BASE + 32'h10);

        // R10: disable in the same cycle as a lookup
        wr(12'h030, 32'h0);
        @(negedge clk);
        in_valid = 1'b1; in_addr = BASE + 32'h13;
        cfg_wr = 1'b1; cfg_addr = 12'h004; cfg_wdata = 32'h0;
        @(negedge clk);
        check(out_hit === 1'b1, "R10 lookup uses old enable", 64'(out_hit), 64'd1);
        in_valid = 1'b0; cfg_wr = 1'b0;
        look(BASE + 32'h13);                 // R2: now off -> miss
        @(negedge clk);
        check(out_hit === 1'b0, "R2 miss when disabled", 64'(out_hit), 64'd0);

        // random sweep over all sizes
        wr(12'h004, 32'h2);
        for (int s = 0; s < 8; s++) begin
            wr(12'h030, 32'(s));
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                in_valid = ($urandom_range(0, 3) != 0);
                in_addr  = BASE - 32'd64 + 32'($urandom_range(0, 2048 * 9));
            end
            @(negedge clk);
            in_valid = 1'b0;
        end
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule